// File: doc/BRIEF.md
# Windowed Level Classifier with Mid-Band Reporting

This block takes a stream of unsigned converter codes that represent an input node voltage. It sorts each valid code into one of three regions: above a programmable upper trip point, below a programmable lower trip point, or in the band between them. Codes above the upper point drive the classified level high and codes below the lower point drive it low. A code inside the band is reported as undecided. It raises a mid-band flag and leaves the level at its last decided value, so a half-driven node is never turned into a logic value by accident.

The band between the two trip points also works as hysteresis. A slow edge carrying noise changes the level only once, because noise that stays inside the band cannot reverse a decision. Two saturating counters record the evidence. One counts how many times the input entered the band. The other counts how many times the decided level changed.

The trip points can be rewritten at run time. A pair that is not strictly ordered is refused, and the pair in force is always exported so it can be audited.

Top module: `vwin_classifier`

## Requirements
- R1: A valid sample whose code is strictly greater than the upper trip point sets `level_o` to 1 and `mid_o` to 0 on the clock edge that takes the sample.
- R2: A valid sample whose code is strictly less than the lower trip point sets `level_o` to 0 and `mid_o` to 0 on the clock edge that takes the sample.
- R3: A valid sample with lower <= code <= upper sets `mid_o` to 1 and leaves `level_o` at its previous value.
- R4: `mid_entries_o` increments by exactly one on each valid sample that lands in the band while `mid_o` is 0. Further band samples do not increment it.
- R5: `crossings_o` increments by one on each valid sample that changes `level_o`. A noisy slow edge that moves between one side and the band and then passes to the other side counts one crossing.
- R6: Both counters are CNT_W bits wide (16 by default) and hold at all ones instead of wrapping.
- R7: A trip-point write with lower >= upper (equality included) is refused. `cfg_err_o` goes to 1 and `thr_lo_o`/`thr_hi_o` keep their previous values.
- R8: A write with lower < upper is accepted. It appears on `thr_lo_o`/`thr_hi_o` one cycle later, applies to samples from the next cycle on, and clears `cfg_err_o`.
- R9: After reset, `level_o`=0, `mid_o`=0, both counters are 0, `cfg_err_o`=0, and the trip points equal the RST_LO/RST_HI parameters (1000/3000 by default).
- R10: While `sample_vld_i` is 0, `level_o`, `mid_o` and both counters hold, whatever the code input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld_i | input | 1 | Sample strobe |
| sample_code_i | input | CODE_W | Unsigned converter code |
| thr_wr_i | input | 1 | Trip-point write strobe |
| thr_lo_i | input | CODE_W | Proposed lower trip point |
| thr_hi_i | input | CODE_W | Proposed upper trip point |
| level_o | output | 1 | Decided level, 1 = ON |
| mid_o | output | 1 | Last valid sample was in the band |
| mid_entries_o | output | CNT_W | Saturating count of band entries |
| crossings_o | output | CNT_W | Saturating count of level changes |
| cfg_err_o | output | 1 | Last trip-point write was refused |
| thr_lo_o | output | CODE_W | Lower trip point in force |
| thr_hi_o | output | CODE_W | Upper trip point in force |

## Verification
Codes are driven exactly at each trip point and one code to either side. This separates strict from inclusive comparisons at both edges of the band. A noisy slow edge, with repeated band samples and dips back out, shows whether the counters tell a band entry apart from a stay in the band, and a real crossing apart from noise. Idle cycles carrying extreme codes show that the strobe gates every state change. A long alternating run of low, band, high and band samples drives both counters to saturation. Refused writes, including an equal pair, followed by probe samples show that the old trip points are still the ones applied.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  localparam int WIDE_W = 16;

  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_BAND = 2'd1,
    RGN_HIGH = 2'd2
  } region_e;

  // Three-way decision: strict above upper, strict below lower, band inclusive.
  function automatic region_e region_of(input logic [WIDE_W-1:0] code,
                                        input logic [WIDE_W-1:0] lo,
                                        input logic [WIDE_W-1:0] hi);
    if (code > hi)      return RGN_HIGH;
    else if (code < lo) return RGN_LOW;
    else                return RGN_BAND;
  endfunction

  // A pair is usable only when strictly ordered.
  function automatic logic pair_ok(input logic [WIDE_W-1:0] lo,
                                   input logic [WIDE_W-1:0] hi);
    return lo < hi;
  endfunction
endpackage

// File: rtl/vwin_cfg.sv
module vwin_cfg #(
  parameter int CODE_W = 12,
  parameter int RST_LO = 1000,
  parameter int RST_HI = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  output logic [CODE_W-1:0] lo_o,
  output logic [CODE_W-1:0] hi_o,
  output logic              err_o,
  output logic              ev_accept_o,
  output logic              ev_reject_o
);
  import vwin_pkg::*;

  logic ordered;
  assign ordered     = pair_ok(WIDE_W'(lo_i), WIDE_W'(hi_i));
  assign ev_accept_o = wr_i && ordered;
  assign ev_reject_o = wr_i && !ordered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o  <= CODE_W'(RST_LO);
      hi_o  <= CODE_W'(RST_HI);
      err_o <= 1'b0;
    end else if (ev_accept_o) begin
      lo_o  <= lo_i;
      hi_o  <= hi_i;
      err_o <= 1'b0;
    end else if (ev_reject_o) begin
      err_o <= 1'b1;
    end
  end

  // R7: the pair in force is always strictly ordered
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_o < hi_o);

  // R7: a refused write leaves the pair untouched and flags the error
  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject_o |=> $stable(lo_o) && $stable(hi_o) && err_o);

  // R8: an accepted write is visible next cycle and clears the error
  p_accept_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_o |=> (lo_o == $past(lo_i)) && (hi_o == $past(hi_i)) && !err_o);
endmodule

// File: rtl/vwin_track.sv
module vwin_track #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  output logic              level_o,
  output logic              mid_o,
  output logic              ev_mid_entry_o,
  output logic              ev_cross_o
);
  import vwin_pkg::*;

  region_e rgn;
  logic    next_level;

  assign rgn = region_of(WIDE_W'(code_i), WIDE_W'(lo_i), WIDE_W'(hi_i));

  always_comb begin
    unique case (rgn)
      RGN_HIGH: next_level = 1'b1;
      RGN_LOW:  next_level = 1'b0;
      default:  next_level = level_o;
    endcase
  end

  assign ev_mid_entry_o = vld_i && (rgn == RGN_BAND) && !mid_o;
  assign ev_cross_o     = vld_i && (rgn != RGN_BAND) && (next_level != level_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= 1'b0;
      mid_o   <= 1'b0;
    end else if (vld_i) begin
      level_o <= next_level;
      mid_o   <= (rgn == RGN_BAND);
    end
  end

  // R1: above the upper trip point decides ON
  p_high_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && code_i > hi_i) |=> level_o && !mid_o);

  // R2: below the lower trip point decides OFF
  p_low_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && code_i < lo_i) |=> !level_o && !mid_o);

  // R3: inside the band the level is held and the flag raised
  p_band_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && code_i >= lo_i && code_i <= hi_i) |=> mid_o && $stable(level_o));

  // R10: no strobe, no state change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(level_o) && $stable(mid_o));

  // R5: a level change is always accompanied by a crossing event
  p_cross_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !ev_cross_o) |=> $stable(level_o));
endmodule

// File: rtl/vwin_satcnt.sv
module vwin_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic at_full;
  assign at_full = (cnt_o == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (inc_i && !at_full) cnt_o <= cnt_o + 1'b1;
  end

  // R6: a full counter stays full
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == FULL) |=> (cnt_o == FULL));

  // R4 / R5: the count moves by at most one per cycle, never down
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

  // R4 / R5: without an event the count holds
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/vwin_classifier.sv
module vwin_classifier #(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 16,
  parameter int RST_LO = 1000,
  parameter int RST_HI = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld_i,
  input  logic [CODE_W-1:0] sample_code_i,
  input  logic              thr_wr_i,
  input  logic [CODE_W-1:0] thr_lo_i,
  input  logic [CODE_W-1:0] thr_hi_i,
  output logic              level_o,
  output logic              mid_o,
  output logic [CNT_W-1:0]  mid_entries_o,
  output logic [CNT_W-1:0]  crossings_o,
  output logic              cfg_err_o,
  output logic [CODE_W-1:0] thr_lo_o,
  output logic [CODE_W-1:0] thr_hi_o
);
  localparam int NUM_CNT = 2;
  localparam int IDX_MID = 0;
  localparam int IDX_CRS = 1;

  logic              ev_accept, ev_reject;
  logic              ev_mid_entry, ev_cross;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];

  vwin_cfg #(.CODE_W(CODE_W), .RST_LO(RST_LO), .RST_HI(RST_HI)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (thr_wr_i),
    .lo_i        (thr_lo_i),
    .hi_i        (thr_hi_i),
    .lo_o        (thr_lo_o),
    .hi_o        (thr_hi_o),
    .err_o       (cfg_err_o),
    .ev_accept_o (ev_accept),
    .ev_reject_o (ev_reject)
  );

  vwin_track #(.CODE_W(CODE_W)) u_track (
    .clk            (clk),
    .rst_n          (rst_n),
    .vld_i          (sample_vld_i),
    .code_i         (sample_code_i),
    .lo_i           (thr_lo_o),
    .hi_i           (thr_hi_o),
    .level_o        (level_o),
    .mid_o          (mid_o),
    .ev_mid_entry_o (ev_mid_entry),
    .ev_cross_o     (ev_cross)
  );

  assign cnt_inc[IDX_MID] = ev_mid_entry;
  assign cnt_inc[IDX_CRS] = ev_cross;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    vwin_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign mid_entries_o = cnt_val[IDX_MID];
  assign crossings_o   = cnt_val[IDX_CRS];

  // R4: band entries and crossings cannot occur on the same sample
  p_event_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_mid_entry && ev_cross));

  // R7: write events are mutually exclusive
  p_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_accept && ev_reject));
endmodule

// File: tb/vwin_classifier_tb_top.sv
`timescale 1ns/1ps
module vwin_classifier_tb_top;
  localparam int CODE_W = 12;
  localparam int CNT_W  = 16;
  localparam int RLO    = 1000;
  localparam int RHI    = 3000;
  localparam logic [CNT_W-1:0] FULL = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_vld_i = 1'b0;
  logic [CODE_W-1:0] sample_code_i = '0;
  logic              thr_wr_i = 1'b0;
  logic [CODE_W-1:0] thr_lo_i = '0;
  logic [CODE_W-1:0] thr_hi_i = '0;
  logic              level_o, mid_o, cfg_err_o;
  logic [CNT_W-1:0]  mid_entries_o, crossings_o;
  logic [CODE_W-1:0] thr_lo_o, thr_hi_o;

  always #2 clk = ~clk;

  vwin_classifier #(.CODE_W(CODE_W), .CNT_W(CNT_W), .RST_LO(RLO), .RST_HI(RHI)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sample_vld_i(sample_vld_i), .sample_code_i(sample_code_i),
    .thr_wr_i(thr_wr_i), .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i),
    .level_o(level_o), .mid_o(mid_o),
    .mid_entries_o(mid_entries_o), .crossings_o(crossings_o),
    .cfg_err_o(cfg_err_o), .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o)
  );

  typedef struct {
    logic              lvl;
    logic              mid;
    logic [CNT_W-1:0]  midc;
    logic [CNT_W-1:0]  crc;
    logic              err;
    logic [CODE_W-1:0] lo;
    logic [CODE_W-1:0] hi;
    string             req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state built from the requirements
  logic              m_lvl = 1'b0, m_mid = 1'b0, m_err = 1'b0;
  logic [CNT_W-1:0]  m_midc = '0, m_crc = '0;
  logic [CODE_W-1:0] m_lo = CODE_W'(RLO), m_hi = CODE_W'(RHI);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == FULL) ? v : v + 1'b1;
  endfunction

  task automatic push(input string req);
    exp_t e;
    e.lvl = m_lvl; e.mid = m_mid; e.midc = m_midc; e.crc = m_crc;
    e.err = m_err; e.lo = m_lo; e.hi = m_hi; e.req = req;
    q.push_back(e);
  endtask

  task automatic drive_sample(input int code, input string req);
    logic in_band, nl;
    @(negedge clk);
    sample_vld_i  = 1'b1;
    sample_code_i = CODE_W'(code);
    thr_wr_i      = 1'b0;
    in_band = 1'b0;
    nl = m_lvl;
    if (code > int'(m_hi))      nl = 1'b1;
    else if (code < int'(m_lo)) nl = 1'b0;
    else                        in_band = 1'b1;
    if (in_band && !m_mid) m_midc = bump(m_midc);
    if (!in_band && nl != m_lvl) m_crc = bump(m_crc);
    m_lvl = nl;
    m_mid = in_band;
    push(req);
  endtask

  task automatic drive_idle(input int code, input string req);
    @(negedge clk);
    sample_vld_i  = 1'b0;
    sample_code_i = CODE_W'(code);
    thr_wr_i      = 1'b0;
    push(req);
  endtask

  task automatic write_thr(input int lo, input int hi, input string req);
    @(negedge clk);
    sample_vld_i = 1'b0;
    thr_wr_i     = 1'b1;
    thr_lo_i     = CODE_W'(lo);
    thr_hi_i     = CODE_W'(hi);
    if (lo < hi) begin
      m_lo = CODE_W'(lo); m_hi = CODE_W'(hi); m_err = 1'b0;
    end else begin
      m_err = 1'b1;
    end
    push(req);
  endtask

  task automatic check_one(input exp_t e);
    checks++;
    if (level_o !== e.lvl || mid_o !== e.mid || mid_entries_o !== e.midc ||
        crossings_o !== e.crc || cfg_err_o !== e.err ||
        thr_lo_o !== e.lo || thr_hi_o !== e.hi) begin
      errors++;
      $display("FAIL %s: actual lvl=%0d mid=%0d midc=%0d crc=%0d err=%0d lo=%0d hi=%0d expected lvl=%0d mid=%0d midc=%0d crc=%0d err=%0d lo=%0d hi=%0d",
               e.req, level_o, mid_o, mid_entries_o, crossings_o, cfg_err_o, thr_lo_o, thr_hi_o,
               e.lvl, e.mid, e.midc, e.crc, e.err, e.lo, e.hi);
    end
  endtask

  // Monitor: one expected item per clock edge, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) check_one(q.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R9: reset state
    e.lvl = 0; e.mid = 0; e.midc = 0; e.crc = 0; e.err = 0;
    e.lo = CODE_W'(RLO); e.hi = CODE_W'(RHI); e.req = "R9 reset state";
    check_one(e);

    // R1 / R2 / R3 at and around both trip points
    drive_sample(RLO - 1, "R2 just below lower");
    drive_sample(RLO,     "R3 at lower is band");
    drive_sample(RHI,     "R3 at upper is band, R4 no re-count");
    drive_sample(RHI + 1, "R1 just above upper");
    drive_sample(RHI,     "R3 band holds ON");
    drive_sample(RLO - 1, "R2 and R5 OFF crossing");
    drive_sample(4095,    "R1 max code");
    drive_sample(0,       "R2 min code");

    // R10: idle cycles with extreme codes
    drive_idle(4095, "R10 idle high code");
    drive_idle(2000, "R10 idle band code");
    drive_idle(0,    "R10 idle low code");

    // R5: slow noisy rising edge gives one crossing
    drive_sample(900,  "R5 noisy edge low");
    drive_sample(1500, "R5 noisy edge band");
    drive_sample(950,  "R5 noise dip out");
    drive_sample(1800, "R5 band again R4");
    drive_sample(2500, "R5 band stay");
    drive_sample(3100, "R5 top crossing");
    drive_sample(2900, "R5 noise into band");
    drive_sample(3200, "R5 back ON no crossing");

    // R7: refused writes keep the old pair
    write_thr(2000, 2000, "R7 equal pair refused");
    write_thr(2500, 1200, "R7 inverted pair refused");
    drive_sample(1100, "R7 old band still applies");
    drive_sample(999,  "R7 old lower still applies");

    // R8: accepted write
    write_thr(500, 600, "R8 accepted write clears error");
    drive_sample(601,  "R8 new upper applied");
    drive_sample(600,  "R8 new upper inclusive band");
    drive_sample(499,  "R8 new lower applied");
    write_thr(RLO, RHI, "R8 restore pair");

    // R6: long alternating run to saturate both counters
    for (int i = 0; i < 33000; i++) begin
      drive_sample(100,  "R6 run low");
      drive_sample(2000, "R6 run band");
      drive_sample(3500, "R6 run high");
      drive_sample(2000, "R6 run band");
    end
    drive_sample(100,  "R6 held at full after crossing");
    drive_sample(2000, "R6 held at full after entry");

    repeat (4) @(posedge clk);
    #1;
    // R6: final explicit saturation check
    checks++;
    if (mid_entries_o !== FULL || crossings_o !== FULL) begin
      errors++;
      $display("FAIL R6 saturation: actual midc=%0d crc=%0d expected %0d", mid_entries_o, crossings_o, FULL);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule